// File: doc/BRIEF.md
# Calibration Memory Controller

This block sits between the control registers of a DAC and its static calibration memory, a 256-entry by 6-bit RAM that holds the trim values the converter applies. It supports several kinds of access. Software can write and read single entries through an address/data pair, and can read single entries of a read-only factory memory. A bulk transfer copies the whole factory memory into the calibration memory. A bulk fill puts the default trim (63) back into every entry. A handshake starts an external self-calibration engine, and while that engine runs it gets the write port.

A two-bit provenance code records where the current contents came from: 00 after the default fill or reset, 01 after self-calibration, 10 after a factory transfer and 11 after a software write. Completion flags report the end of a transfer and the end of a self-calibration. The block also divides its clock into a calibration tick whose period is set by a 3-bit power-of-two selector. Both memories sit outside the block and are read synchronously, with data returned one cycle after the address.

Top module: `cal_mem_ctrl`

## Requirements
- R1: After reset, the provenance code is 00, both completion flags, `busy`, `rd_valid` and `cal_start` are 0.
- R2: When idle with `smem_wr_ena` high, a `smem_wr_req` cycle writes `acc_wdata` to entry `acc_addr` in that cycle and sets the provenance code to 11 on the next cycle. With `smem_wr_ena` low the request has no effect on memory or code.
- R3: When idle, a `smem_rd_req` with `smem_rd_ena` high, or an `fmem_rd_req` with `fmem_rd_ena` high, returns the entry at `acc_addr` on `rd_data` with `rd_valid` high in the following cycle. A request whose enable is low produces no `rd_valid`.
- R4: A `xfer_go` copies factory entry a into calibration entry a for all 256 addresses, one per clock. `busy` is high for 257 cycles, and at the end `xfer_done` is 1 and the code is 10.
- R5: A `fill_go` writes 63 to all 256 entries, one per clock, with `busy` high for 256 cycles, and the code returns to 00.
- R6: A `cal_go` raises `cal_start` for exactly one cycle. The engine write port (`eng_*`) drives the memory until `cal_fin`, after which `scal_done` is 1, the code is 01 and `busy` drops.
- R7: Both completion flags clear in the cycle after any bulk operation (transfer, fill or calibration) starts.
- R8: While `busy` is high, every bulk command and every software access is ignored.
- R9: When several commands arrive in the same idle cycle, fill wins over transfer, transfer wins over calibration, and any bulk command wins over software access.
- R10: `cal_tick` pulses for one cycle every 4096 >> `cal_div` clock cycles (4096 for code 000, 32 for code 111).
- R11: `cal_fin` has no effect when no calibration is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (DAC clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| smem_wr_ena | input | 1 | Enables software writes to calibration memory |
| smem_rd_ena | input | 1 | Enables software reads of calibration memory |
| fmem_rd_ena | input | 1 | Enables software reads of factory memory |
| acc_addr | input | 8 | Address for software access |
| acc_wdata | input | 6 | Data for software writes |
| smem_wr_req | input | 1 | Software write strobe |
| smem_rd_req | input | 1 | Software calibration-memory read strobe |
| fmem_rd_req | input | 1 | Software factory-memory read strobe |
| xfer_go | input | 1 | Start factory-to-calibration copy |
| fill_go | input | 1 | Start default fill |
| cal_go | input | 1 | Start self-calibration |
| cal_div | input | 3 | Calibration tick divider selector |
| cal_fin | input | 1 | Engine reports end of calibration |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 8 | Engine write address |
| eng_wdata | input | 6 | Engine write data |
| smem_rdata | input | 6 | Calibration memory read data (one cycle latency) |
| fmem_rdata | input | 6 | Factory memory read data (one cycle latency) |
| rd_data | output | 6 | Software read result |
| rd_valid | output | 1 | `rd_data` is valid |
| busy | output | 1 | A bulk operation is in progress |
| cal_code | output | 2 | Provenance code of memory contents |
| xfer_done | output | 1 | Transfer completed |
| scal_done | output | 1 | Self-calibration completed |
| cal_start | output | 1 | One-cycle start pulse to the engine |
| cal_tick | output | 1 | Divided calibration tick |
| smem_we | output | 1 | Calibration memory write enable |
| smem_addr | output | 8 | Calibration memory address |
| smem_wdata | output | 6 | Calibration memory write data |
| fmem_addr | output | 8 | Factory memory address |

## Verification
On every cycle, assertions watch how the status bits follow the events: a completion flag rises only together with the matching provenance code, an accepted software write turns into code 11, a stray `cal_fin` leaves status alone, `cal_start` never lasts more than a cycle, a fill only ever writes 63, and ticks never come back to back. Some behaviour only shows over whole operations, and the bench's scenarios cover it. These are the full memory contents after a copy or fill, the exact busy lengths, the arbitration between simultaneous commands, commands dropped in the middle of a transfer, the read data returned through the scoreboard, and the exact tick period for several selector codes.

// File: rtl/cal_mem_ctrl.sv
`timescale 1ns/1ps
module cal_mem_ctrl #(
  parameter int AW   = 8,
  parameter int DW   = 6,
  parameter int DIVW = 12,
  parameter int SELW = 3,
  parameter logic [DW-1:0] DEF_VAL = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smem_wr_ena,
  input  logic            smem_rd_ena,
  input  logic            fmem_rd_ena,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  input  logic            smem_wr_req,
  input  logic            smem_rd_req,
  input  logic            fmem_rd_req,
  input  logic            xfer_go,
  input  logic            fill_go,
  input  logic            cal_go,
  input  logic [SELW-1:0] cal_div,
  input  logic            cal_fin,
  input  logic            eng_we,
  input  logic [AW-1:0]   eng_addr,
  input  logic [DW-1:0]   eng_wdata,
  input  logic [DW-1:0]   smem_rdata,
  input  logic [DW-1:0]   fmem_rdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            busy,
  output logic [1:0]      cal_code,
  output logic            xfer_done,
  output logic            scal_done,
  output logic            cal_start,
  output logic            cal_tick,
  output logic            smem_we,
  output logic [AW-1:0]   smem_addr,
  output logic [DW-1:0]   smem_wdata,
  output logic [AW-1:0]   fmem_addr
);
  localparam logic [AW-1:0] LAST = '1;
  localparam logic [1:0] C_UNCAL = 2'b00, C_SELF = 2'b01, C_FACT = 2'b10, C_USER = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FILL, S_CAL} st_t;

  st_t st;
  logic [AW-1:0] idx, pend_addr;
  logic pend, rd_pend, rd_f;
  logic [DIVW-1:0] div_cnt;

  assign busy = (st != S_IDLE) || pend;

  wire idle    = !busy;
  wire go_any  = idle && (fill_go || xfer_go || cal_go);
  wire do_fill = idle && fill_go;
  wire do_xfer = idle && xfer_go && !fill_go;
  wire do_cal  = idle && cal_go && !fill_go && !xfer_go;
  wire usr_wr  = idle && !go_any && smem_wr_ena && smem_wr_req;
  wire usr_rd  = idle && !go_any && !usr_wr && smem_rd_ena && smem_rd_req;
  wire usr_frd = idle && !go_any && !usr_wr && !usr_rd && fmem_rd_ena && fmem_rd_req;

  always_comb begin
    smem_we    = 1'b0;
    smem_addr  = acc_addr;
    smem_wdata = acc_wdata;
    if (pend) begin
      smem_we    = 1'b1;
      smem_addr  = pend_addr;
      smem_wdata = fmem_rdata;
    end else begin
      case (st)
        S_FILL: begin
          smem_we    = 1'b1;
          smem_addr  = idx;
          smem_wdata = DEF_VAL;
        end
        S_CAL: begin
          smem_we    = eng_we;
          smem_addr  = eng_addr;
          smem_wdata = eng_wdata;
        end
        default: smem_we = usr_wr;
      endcase
    end
  end

  assign fmem_addr = (st == S_XFER) ? idx : acc_addr;
  assign rd_data   = rd_f ? fmem_rdata : smem_rdata;
  assign rd_valid  = rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      rd_pend   <= 1'b0;
      rd_f      <= 1'b0;
      cal_code  <= C_UNCAL;
      xfer_done <= 1'b0;
      scal_done <= 1'b0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= do_cal;
      rd_pend   <= usr_rd || usr_frd;
      rd_f      <= usr_frd;
      pend      <= (st == S_XFER);
      pend_addr <= idx;
      if (go_any) begin
        xfer_done <= 1'b0;
        scal_done <= 1'b0;
        idx       <= '0;
      end
      if (usr_wr) cal_code <= C_USER;
      if (pend && pend_addr == LAST) begin
        xfer_done <= 1'b1;
        cal_code  <= C_FACT;
      end
      case (st)
        S_IDLE: begin
          if (do_fill)      st <= S_FILL;
          else if (do_xfer) st <= S_XFER;
          else if (do_cal)  st <= S_CAL;
        end
        S_XFER, S_FILL: begin
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            st <= S_IDLE;
            if (st == S_FILL) cal_code <= C_UNCAL;
          end
        end
        S_CAL: begin
          if (cal_fin) begin
            st        <= S_IDLE;
            scal_done <= 1'b1;
            cal_code  <= C_SELF;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  wire [DIVW-1:0] div_mask = {DIVW{1'b1}} >> cal_div;
  assign cal_tick = (div_cnt & div_mask) == div_mask;

  // R6
  cal_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  // R4
  xfer_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> cal_code == C_FACT);

  // R6
  scal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scal_done) |-> cal_code == C_SELF);

  // R2
  usr_wr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smem_wr_req && smem_wr_ena && !busy && !fill_go && !xfer_go && !cal_go)
      |=> cal_code == C_USER);

  // R5
  fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && smem_we) |-> smem_wdata == DEF_VAL);

  // R10
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_tick |=> !cal_tick);

  // R11
  fin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_fin && !busy && !fill_go && !xfer_go && !cal_go && !smem_wr_req)
      |=> ($stable(scal_done) && $stable(cal_code)));

  // R8
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cal_go) |=> !cal_start);
endmodule

// File: tb/test_cal_mem_ctrl.sv
`timescale 1ns/1ps
module test_cal_mem_ctrl;
  logic clk = 0, rst_n = 0;
  logic smem_wr_ena = 0, smem_rd_ena = 0, fmem_rd_ena = 0;
  logic [7:0] acc_addr = 0;
  logic [5:0] acc_wdata = 0;
  logic smem_wr_req = 0, smem_rd_req = 0, fmem_rd_req = 0;
  logic xfer_go = 0, fill_go = 0, cal_go = 0;
  logic [2:0] cal_div = 0;
  logic cal_fin = 0, eng_we = 0;
  logic [7:0] eng_addr = 0;
  logic [5:0] eng_wdata = 0;
  logic [5:0] smem_rdata, fmem_rdata;
  logic [5:0] rd_data;
  logic rd_valid, busy, xfer_done, scal_done, cal_start, cal_tick, smem_we;
  logic [1:0] cal_code;
  logic [7:0] smem_addr, fmem_addr;
  logic [5:0] smem_wdata;

  int checks = 0, errors = 0, n_valid = 0, n_start = 0;
  logic [5:0] smem_arr [256];
  logic [5:0] exp_mem [256];
  logic [5:0] exp_q [$];

  always #5 clk = ~clk;

  cal_mem_ctrl i_cal_mem_ctrl (
    .clk, .rst_n, .smem_wr_ena, .smem_rd_ena, .fmem_rd_ena, .acc_addr, .acc_wdata,
    .smem_wr_req, .smem_rd_req, .fmem_rd_req, .xfer_go, .fill_go, .cal_go, .cal_div,
    .cal_fin, .eng_we, .eng_addr, .eng_wdata, .smem_rdata, .fmem_rdata, .rd_data,
    .rd_valid, .busy, .cal_code, .xfer_done, .scal_done, .cal_start, .cal_tick,
    .smem_we, .smem_addr, .smem_wdata, .fmem_addr
  );

  function automatic logic [5:0] fval(input int a);
    return 6'((a * 7 + 3) % 64);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) smem_arr[i] <= '0;
      smem_rdata <= '0;
      fmem_rdata <= '0;
    end else begin
      if (smem_we) smem_arr[smem_addr] <= smem_wdata;
      smem_rdata <= smem_arr[smem_addr];
      fmem_rdata <= fval(int'(fmem_addr));
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cal_start) n_start++;
    if (rd_valid) begin
      n_valid++;
      if (exp_q.size() == 0) chk("R3 unexpected rd_valid", 1, 0);
      else chk("R3 read data", int'(rd_data), int'(exp_q.pop_front()));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic usr_write(input int a, input int d, input bit ena, input bit accept);
    acc_addr = 8'(a); acc_wdata = 6'(d); smem_wr_ena = ena; smem_wr_req = 1;
    step();
    smem_wr_req = 0;
    if (accept) exp_mem[a] = 6'(d);
  endtask

  task automatic usr_read(input int a, input bit from_f);
    acc_addr = 8'(a);
    if (from_f) fmem_rd_req = 1; else smem_rd_req = 1;
    exp_q.push_back(from_f ? fval(a) : exp_mem[a]);
    step();
    smem_rd_req = 0; fmem_rd_req = 0;
    step();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    step();
  endtask

  task automatic mem_cmp(input string tag);
    int mism = 0;
    for (int a = 0; a < 256; a++) if (smem_arr[a] !== exp_mem[a]) mism++;
    chk(tag, mism, 0);
  endtask

  task automatic tick_gap(output int g);
    @(negedge clk);
    while (!cal_tick) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!cal_tick);
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int n, g, s0, v0;
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 code", int'(cal_code), 0);
    chk("R1 flags", int'({xfer_done, scal_done}), 0);
    chk("R1 busy/valid/start", int'({busy, rd_valid, cal_start}), 0);
    step();

    // R2 software write with and without enable
    usr_write(10, 21, 1, 1);
    @(negedge clk); chk("R2 code after write", int'(cal_code), 3);
    step();
    usr_write(11, 5, 0, 0);
    smem_rd_ena = 1;
    usr_read(10, 0);
    usr_read(11, 0);

    // R3 read without enable produces nothing
    smem_rd_ena = 0; v0 = n_valid;
    acc_addr = 10; smem_rd_req = 1; step(); smem_rd_req = 0; step(); step();
    chk("R3 no valid without enable", n_valid, v0);
    fmem_rd_ena = 1; smem_rd_ena = 1;
    usr_read(7, 1);
    usr_read(200, 1);

    // R4 transfer
    xfer_go = 1; step(); xfer_go = 0;
    wait_idle(n);
    chk("R4 busy cycles", n, 257);
    chk("R4 done flag", int'(xfer_done), 1);
    chk("R4 code", int'(cal_code), 2);
    for (int a = 0; a < 256; a++) exp_mem[a] = fval(a);
    mem_cmp("R4 contents");
    usr_read(3, 0);

    // R8 commands ignored mid-transfer
    xfer_go = 1; step(); xfer_go = 0;
    repeat (10) step();
    usr_write(3, 9, 1, 0);
    fill_go = 1; cal_go = 1; step(); fill_go = 0; cal_go = 0;
    s0 = n_start; v0 = n_valid;
    acc_addr = 4; smem_rd_req = 1; step(); smem_rd_req = 0;
    wait_idle(n);
    chk("R8 no calibration started", n_start, s0);
    chk("R8 no read while busy", n_valid, v0);
    chk("R8 code kept", int'(cal_code), 2);
    mem_cmp("R8 contents untouched");

    // R5 fill, R7 flag clear
    fill_go = 1; step(); fill_go = 0;
    wait_idle(n);
    chk("R5 busy cycles", n, 256);
    chk("R5 code", int'(cal_code), 0);
    chk("R7 xfer_done cleared", int'(xfer_done), 0);
    for (int a = 0; a < 256; a++) exp_mem[a] = 6'd63;
    mem_cmp("R5 contents");

    // R11 stray finish
    cal_fin = 1; step(); cal_fin = 0;
    @(negedge clk);
    chk("R11 scal_done", int'(scal_done), 0);
    chk("R11 code", int'(cal_code), 0);
    step();

    // R6 calibration handshake
    cal_go = 1; step(); cal_go = 0;
    @(negedge clk); chk("R6 start pulse", int'(cal_start), 1);
    step();
    @(negedge clk); chk("R6 start one cycle", int'(cal_start), 0);
    chk("R6 busy during cal", int'(busy), 1);
    step();
    eng_we = 1; eng_addr = 5; eng_wdata = 12; step(); eng_we = 0;
    exp_mem[5] = 6'd12;
    cal_fin = 1; step(); cal_fin = 0;
    @(negedge clk);
    chk("R6 scal_done", int'(scal_done), 1);
    chk("R6 code", int'(cal_code), 1);
    chk("R6 busy released", int'(busy), 0);
    step();
    usr_read(5, 0);

    // R7 flag clears when transfer starts
    xfer_go = 1; step(); xfer_go = 0;
    @(negedge clk); chk("R7 scal_done cleared", int'(scal_done), 0);
    wait_idle(n);
    for (int a = 0; a < 256; a++) exp_mem[a] = fval(a);

    // R9 priorities
    s0 = n_start;
    fill_go = 1; xfer_go = 1; cal_go = 1; step();
    fill_go = 0; xfer_go = 0; cal_go = 0;
    wait_idle(n);
    chk("R9 fill wins busy", n, 256);
    chk("R9 fill wins code", int'(cal_code), 0);
    chk("R9 no cal start", n_start, s0);
    for (int a = 0; a < 256; a++) exp_mem[a] = 6'd63;
    mem_cmp("R9 fill contents");
    xfer_go = 1; cal_go = 1; acc_addr = 9; acc_wdata = 1; smem_wr_ena = 1; smem_wr_req = 1;
    step();
    xfer_go = 0; cal_go = 0; smem_wr_req = 0;
    wait_idle(n);
    chk("R9 transfer wins busy", n, 257);
    chk("R9 transfer wins code", int'(cal_code), 2);
    chk("R9 no cal start 2", n_start, s0);
    for (int a = 0; a < 256; a++) exp_mem[a] = fval(a);
    mem_cmp("R9 transfer contents");

    // R10 divider
    cal_div = 3'd7; tick_gap(g); tick_gap(g); chk("R10 code 7", g, 32);
    cal_div = 3'd5; tick_gap(g); tick_gap(g); chk("R10 code 5", g, 128);
    cal_div = 3'd0; tick_gap(g); tick_gap(g); chk("R10 code 0", g, 4096);

    repeat (3) step();
    chk("R3 reads outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule